// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

This block sits on the data-space write path of a small microcontroller. A store from the CPU normally lands in the on-chip data RAM (XRAM); when software sets a write-enable bit in the control register, the same store is steered toward the non-volatile array instead. Data-space loads never see the array and always return XRAM contents.

Every flash operation is guarded by a two-code unlock performed through a key register. Any bad or out-of-order code locks the sequencer until reset. The block times program and erase operations in hardware and shows a busy flag while one runs. It applies flash semantics: a program can only clear bits, and an erase sets a whole 512-byte page to ones.

Writes into the reserved top kilobyte are refused. A flash attempt made while the supply monitor is disabled raises a one-cycle error-reset request and leaves the array untouched. The array itself is a behavioural register model with a code read port.

Top module: `kflash_ctrl`

## Requirements
- R1: With control bit 0 (write enable) at 0, a data-space write stores into XRAM and leaves the array unchanged. With it at 1, the write is a flash attempt and XRAM is unchanged.
- R2: The control register sits at register address 0. Bit 0 is the write enable and bit 1 is the erase enable. It reads back its value, and it keeps that value until software rewrites it.
- R3: The data-space read port returns XRAM contents whatever the state of the write enable.
- R4: Writing 0xA5 and then 0xF1 to the key register (address 1), with any gap between them, permits exactly one flash operation. The next operation needs both codes again.
- R5: Any other code, or the codes out of order, locks the sequencer until reset. While it is locked, no flash attempt changes the array.
- R6: A program stores the old byte ANDed with the new data.
- R7: With both enable bits set, a flash attempt erases the 512-byte page that holds the address, setting every byte to 0xFF. Other pages are untouched.
- R8: The busy port and status register (address 2) bit 0 read 1 for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. The defaults are 40 and 400. The array holds its new value once busy falls.
- R9: While busy is 1, key-register writes and data-space flash attempts are ignored.
- R10: A flash attempt with vdd_mon_en at 0 pulses flash_err_rst for one cycle in the cycle after the write. The array is unchanged and a pending unlock is spent.
- R11: A flash attempt at an address of 0x7C00 or above is refused with no busy period. A pending unlock is spent.
- R12: A flash attempt with no completed unlock is ignored and does not lock the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_mon_en | input | 1 | Supply monitor enabled |
| dw_valid | input | 1 | Data-space write strobe |
| dw_addr | input | 16 | Data-space write address |
| dw_data | input | 8 | Data-space write data |
| dr_addr | input | 10 | Data-space (XRAM) read address |
| dr_data | output | 8 | Data-space read data |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 2 | Register select: 0 control, 1 key, 2 status |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data |
| code_addr | input | 15 | Array read address |
| code_data | output | 8 | Array read data |
| busy | output | 1 | Operation in progress |
| flash_err_rst | output | 1 | Flash-error reset request pulse |

## Verification
The bench aims at the interplay of the unlock sequencer with everything around it. It stretches the gap between the two codes and sends a bad key while an operation runs; a design that ignored busy there would lock and refuse the next keyed program. It repeats a program over a partially cleared byte, which a design that overwrote instead of ANDing would get wrong. It erases a neighbouring page to show that the first page survives, which an off-by-one page decode would corrupt. It makes reserved-area and monitor-off attempts to prove that they spend the unlock, so a design that kept the unlock armed would accept a later unkeyed program.

// File: rtl/kfl_pkg.sv
package kfl_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'hF1;

  localparam logic [1:0] SFR_CTRL = 2'd0;
  localparam logic [1:0] SFR_KEY  = 2'd1;
  localparam logic [1:0] SFR_STAT = 2'd2;

  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_HALF   = 2'd1,
    KS_ARMED  = 2'd2,
    KS_LOCKED = 2'd3
  } key_st_e;
endpackage

// File: rtl/kfl_keyseq.sv
module kfl_keyseq
  import kfl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_data,
  input  logic       busy,
  input  logic       consume,
  output logic       armed
);
  key_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (consume) begin
      state_d = KS_IDLE;
    end else if (key_we && !busy) begin
      unique case (state_q)
        KS_IDLE:   state_d = (key_data == KEY_FIRST)  ? KS_HALF  : KS_LOCKED;
        KS_HALF:   state_d = (key_data == KEY_SECOND) ? KS_ARMED : KS_LOCKED;
        KS_ARMED:  state_d = KS_LOCKED;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == KS_ARMED);

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == KS_LOCKED |=> state_q == KS_LOCKED); // R5
  AST_BUSY_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_we) |=> $stable(state_q)); // R9
endmodule

// File: rtl/kfl_optimer.sv
module kfl_optimer #(
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic erase,
  output logic busy,
  output logic done
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  assign done   = busy_q && (cnt_q == CW'(1));
  assign cnt_en = start || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CW'(1);
      busy_d = !done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q); // R8
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R9
endmodule

// File: rtl/kfl_array.sv
module kfl_array #(
  parameter int FLASH_BYTES = 32768,
  parameter int PAGE_BYTES  = 512,
  parameter int ROW_BYTES   = 32,
  parameter int RESV_BASE   = 32'h7C00
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           prog_en,
  input  logic                           erase_en,
  input  logic [$clog2(FLASH_BYTES)-1:0] addr,
  input  logic [7:0]                     wdata,
  input  logic [$clog2(FLASH_BYTES)-1:0] rd_addr,
  output logic [7:0]                     rd_data
);
  localparam int FA_W     = $clog2(FLASH_BYTES);
  localparam int RB_W     = $clog2(ROW_BYTES);
  localparam int PG_W     = $clog2(PAGE_BYTES);
  localparam int ROWS     = FLASH_BYTES / ROW_BYTES;
  localparam int ROW_BITS = ROW_BYTES * 8;
  localparam int RPP      = PAGE_BYTES / ROW_BYTES;
  localparam int RPP_W    = PG_W - RB_W;
  localparam int RW_W     = FA_W - RB_W;

  logic [ROW_BITS-1:0] mem [ROWS];

  logic [RW_W-1:0]      wr_row, rd_row;
  logic [RB_W-1:0]      wr_lane, rd_lane;
  logic [FA_W-PG_W-1:0] wr_page;

  assign wr_row  = addr[FA_W-1:RB_W];
  assign wr_lane = addr[RB_W-1:0];
  assign wr_page = addr[FA_W-1:PG_W];
  assign rd_row  = rd_addr[FA_W-1:RB_W];
  assign rd_lane = rd_addr[RB_W-1:0];

  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int r = 0; r < RPP; r++) begin
        mem[{wr_page, RPP_W'(r)}] <= '1;
      end
    end else if (prog_en) begin
      mem[wr_row][{wr_lane, 3'b000} +: 8] <= mem[wr_row][{wr_lane, 3'b000} +: 8] & wdata;
    end
  end

  assign rd_data = mem[rd_row][{rd_lane, 3'b000} +: 8];

  AST_OP_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en || erase_en) |-> (32'(addr) < RESV_BASE)); // R11
  AST_ONE_OP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && erase_en)); // R7
endmodule

// File: rtl/kfl_xram.sv
module kfl_xram #(
  parameter int XRAM_BYTES = 1024
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [$clog2(XRAM_BYTES)-1:0] waddr,
  input  logic [7:0]                    wdata,
  input  logic [$clog2(XRAM_BYTES)-1:0] raddr,
  output logic [7:0]                    rdata
);
  logic [7:0] mem [XRAM_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/kflash_ctrl.sv
module kflash_ctrl
  import kfl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int FLASH_BYTES = 32768,
  parameter int RESV_BASE   = 32'h7C00,
  parameter int PAGE_BYTES  = 512,
  parameter int ROW_BYTES   = 32,
  parameter int XRAM_BYTES  = 1024,
  parameter int PROG_CYC    = 40,
  parameter int ERASE_CYC   = 400
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           vdd_mon_en,
  input  logic                           dw_valid,
  input  logic [ADDR_W-1:0]              dw_addr,
  input  logic [7:0]                     dw_data,
  input  logic [$clog2(XRAM_BYTES)-1:0]  dr_addr,
  output logic [7:0]                     dr_data,
  input  logic                           sfr_we,
  input  logic [1:0]                     sfr_addr,
  input  logic [7:0]                     sfr_wdata,
  output logic [7:0]                     sfr_rdata,
  input  logic [$clog2(FLASH_BYTES)-1:0] code_addr,
  output logic [7:0]                     code_data,
  output logic                           busy,
  output logic                           flash_err_rst
);
  localparam int FA_W = $clog2(FLASH_BYTES);
  localparam int XA_W = $clog2(XRAM_BYTES);

  logic            wren_q, wren_d, eren_q, eren_d, ctrl_en;
  logic            key_we, armed, consume;
  logic            flash_try, addr_ok, start, vdd_bad;
  logic            err_q, err_d;
  logic [FA_W-1:0] op_addr_q;
  logic [7:0]      op_data_q;
  logic            op_erase_q;
  logic            done, prog_fire, erase_fire, xram_we;

  // control register
  assign ctrl_en = sfr_we && (sfr_addr == SFR_CTRL);
  always_comb begin
    wren_d = wren_q;
    eren_d = eren_q;
    if (ctrl_en) begin
      wren_d = sfr_wdata[0];
      eren_d = sfr_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      eren_q <= 1'b0;
    end else if (ctrl_en) begin
      wren_q <= wren_d;
      eren_q <= eren_d;
    end
  end

  // write steering and gating
  assign key_we    = sfr_we && (sfr_addr == SFR_KEY);
  assign xram_we   = dw_valid && !wren_q;
  assign flash_try = dw_valid && wren_q && !busy;
  assign addr_ok   = (32'(dw_addr) < RESV_BASE);
  assign vdd_bad   = flash_try && !vdd_mon_en;
  assign start     = flash_try && vdd_mon_en && armed && addr_ok;
  assign consume   = flash_try && armed;
  assign err_d     = vdd_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q  <= '0;
      op_data_q  <= '0;
      op_erase_q <= 1'b0;
    end else if (start) begin
      op_addr_q  <= dw_addr[FA_W-1:0];
      op_data_q  <= dw_data;
      op_erase_q <= eren_q;
    end
  end

  kfl_keyseq u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_we),
    .key_data (sfr_wdata),
    .busy     (busy),
    .consume  (consume),
    .armed    (armed)
  );

  kfl_optimer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .erase (eren_q),
    .busy  (busy),
    .done  (done)
  );

  assign prog_fire  = done && !op_erase_q;
  assign erase_fire = done && op_erase_q;

  kfl_array #(
    .FLASH_BYTES (FLASH_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .ROW_BYTES   (ROW_BYTES),
    .RESV_BASE   (RESV_BASE)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (prog_fire),
    .erase_en (erase_fire),
    .addr     (op_addr_q),
    .wdata    (op_data_q),
    .rd_addr  (code_addr),
    .rd_data  (code_data)
  );

  kfl_xram #(
    .XRAM_BYTES (XRAM_BYTES)
  ) u_xram (
    .clk   (clk),
    .we    (xram_we),
    .waddr (dw_addr[XA_W-1:0]),
    .wdata (dw_data),
    .raddr (dr_addr),
    .rdata (dr_data)
  );

  always_comb begin
    unique case (sfr_addr)
      SFR_CTRL: sfr_rdata = {6'b0, eren_q, wren_q};
      SFR_STAT: sfr_rdata = {7'b0, busy};
      default:  sfr_rdata = 8'h00;
    endcase
  end

  assign flash_err_rst = err_q;

  AST_ERR_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    flash_err_rst |-> !$rose(busy)); // R10
  AST_XRAM_PATH_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && !wren_q && !busy) |=> !busy); // R1
endmodule

// File: tb/kflash_ctrl_tb.sv
`timescale 1ns/100ps
module kflash_ctrl_tb;
  localparam int PROG_CYC  = 40;
  localparam int ERASE_CYC = 400;

  logic        clk, rst_n, vdd_mon_en, dw_valid, sfr_we;
  logic [15:0] dw_addr;
  logic [7:0]  dw_data, sfr_wdata, sfr_rdata, dr_data, code_data;
  logic [9:0]  dr_addr;
  logic [1:0]  sfr_addr;
  logic [14:0] code_addr;
  logic        busy, flash_err_rst;

  int nchk = 0;
  int nerr = 0;

  // scoreboard: kind 0 = array byte, 1 = XRAM byte
  string rq[$];
  int    kq[$];
  int    aq[$];
  int    eq[$];

  kflash_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .vdd_mon_en(vdd_mon_en),
    .dw_valid(dw_valid), .dw_addr(dw_addr), .dw_data(dw_data),
    .dr_addr(dr_addr), .dr_data(dr_data),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .code_addr(code_addr), .code_data(code_data),
    .busy(busy), .flash_err_rst(flash_err_rst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input string req, input int kind, input int addr, input int exp);
    rq.push_back(req); kq.push_back(kind); aq.push_back(addr); eq.push_back(exp);
    while (kq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the read ports
  initial begin
    code_addr = '0;
    dr_addr   = '0;
    forever begin
      @(negedge clk);
      if (kq.size() != 0) begin
        string r;
        int k, a, e;
        r = rq[0]; k = kq[0]; a = aq[0]; e = eq[0];
        if (k == 0) code_addr = a[14:0];
        else        dr_addr   = a[9:0];
        #1;
        chk(r, (k == 0) ? int'(code_data) : int'(dr_data), e);
        void'(rq.pop_front()); void'(kq.pop_front());
        void'(aq.pop_front()); void'(eq.pop_front());
      end
    end
  end

  task automatic sfr_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_read(input logic [1:0] a, output int d);
    sfr_addr = a;
    #1;
    d = int'(sfr_rdata);
  endtask

  task automatic dw_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    dw_valid = 1'b1; dw_addr = a; dw_data = d;
    @(negedge clk);
    dw_valid = 1'b0;
  endtask

  task automatic unlock();
    sfr_write(2'd1, 8'hA5);
    sfr_write(2'd1, 8'hF1);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int v, n;
    rst_n = 1'b0; vdd_mon_en = 1'b1; dw_valid = 1'b0; dw_addr = '0; dw_data = '0;
    sfr_we = 1'b0; sfr_addr = '0; sfr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    sfr_read(2'd0, v); chk("R2 reset ctrl", v, 0);
    sfr_read(2'd2, v); chk("R8 reset status", v, 0);
    chk("R10 reset err", int'(flash_err_rst), 0);

    // R1: XRAM write with enable off
    dw_write(16'h0010, 8'h3C);
    expect_item("R1 xram write", 1, 16'h0010, 8'h3C);

    // R7: erase page 0 via address 0x0010
    sfr_write(2'd0, 8'h03);
    sfr_read(2'd0, v); chk("R2 ctrl readback", v, 3);
    unlock();
    dw_write(16'h0010, 8'h00);
    sfr_read(2'd2, v); chk("R8 status busy", v, 1);
    busy_len(n); chk("R8 erase length", n, ERASE_CYC);
    expect_item("R7 erase low", 0, 16'h0000, 8'hFF);
    expect_item("R7 erase high", 0, 16'h01FF, 8'hFF);
    expect_item("R3 xram read with enable on", 1, 16'h0010, 8'h3C);

    // R6: program and AND
    sfr_write(2'd0, 8'h01);
    unlock();
    dw_write(16'h0020, 8'hF0);
    busy_len(n); chk("R8 program length", n, PROG_CYC);
    expect_item("R6 first program", 0, 16'h0020, 8'hF0);
    unlock();
    dw_write(16'h0020, 8'h3F);
    busy_len(n);
    expect_item("R6 AND program", 0, 16'h0020, 8'h30);

    // R12 and R4 re-arm: no keys, ignored
    dw_write(16'h0021, 8'h00);
    chk("R12 no busy without unlock", int'(busy), 0);
    expect_item("R4 one op per unlock", 0, 16'h0021, 8'hFF);

    // R4: long gap between codes
    sfr_write(2'd1, 8'hA5);
    repeat (50) @(negedge clk);
    sfr_write(2'd1, 8'hF1);
    dw_write(16'h0022, 8'h55);
    busy_len(n);
    expect_item("R4 gap between codes", 0, 16'h0022, 8'h55);

    // R9: bad key and flash write during busy are ignored
    unlock();
    dw_write(16'h0023, 8'h0F);
    sfr_write(2'd1, 8'h00);
    dw_write(16'h0024, 8'h00);
    busy_len(n);
    expect_item("R9 op result", 0, 16'h0023, 8'h0F);
    expect_item("R9 write during busy ignored", 0, 16'h0024, 8'hFF);
    unlock();
    dw_write(16'h0024, 8'hAA);
    busy_len(n);
    expect_item("R9 key during busy did not lock", 0, 16'h0024, 8'hAA);

    // R11: reserved area rejected and unlock spent
    unlock();
    dw_write(16'h7C00, 8'h00);
    chk("R11 reserved no busy", int'(busy), 0);
    dw_write(16'h0025, 8'h11);
    chk("R11 unlock spent", int'(busy), 0);
    expect_item("R11 later write ignored", 0, 16'h0025, 8'hFF);

    // R10: supply monitor off
    vdd_mon_en = 1'b0;
    unlock();
    dw_write(16'h0026, 8'h00);
    chk("R10 err pulse", int'(flash_err_rst), 1);
    chk("R10 no busy", int'(busy), 0);
    @(negedge clk);
    chk("R10 pulse one cycle", int'(flash_err_rst), 0);
    vdd_mon_en = 1'b1;
    expect_item("R10 array unchanged", 0, 16'h0026, 8'hFF);

    // R7: erase neighbouring page keeps page 0
    sfr_write(2'd0, 8'h03);
    unlock();
    dw_write(16'h03FF, 8'h00);
    busy_len(n);
    expect_item("R7 next page erased", 0, 16'h0200, 8'hFF);
    expect_item("R7 page 0 kept", 0, 16'h0020, 8'h30);

    // R1: XRAM write with enable off leaves array
    sfr_write(2'd0, 8'h00);
    dw_write(16'h0020, 8'h00);
    expect_item("R1 array untouched", 0, 16'h0020, 8'h30);
    expect_item("R1 xram updated", 1, 16'h0020, 8'h00);

    // R5: wrong first code locks for good
    sfr_write(2'd0, 8'h01);
    sfr_write(2'd1, 8'hF1);
    unlock();
    dw_write(16'h0027, 8'h00);
    chk("R5 locked no busy", int'(busy), 0);
    expect_item("R5 locked array", 0, 16'h0027, 8'hFF);
    sfr_read(2'd0, v); chk("R2 ctrl held", v, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule